// File: doc/BRIEF.md
# SM4 Round Key Generator

This unit expands a 128-bit SM4 cipher key into the 32 round keys of the key schedule. A key is offered on a valid/ready request. Once the unit accepts it, the unit runs one schedule round per clock cycle. It writes each new 32-bit round key into an internal 32-entry register file. When the last key has been written, a done flag rises. Any stored round key can then be fetched by its index through a registered read port.

The working state is four 32-bit words. The fixed family constant is folded into the key only in the first round. The per-round constants are computed from the round index rather than stored. The byte substitution table is also computed from its algebraic definition, as an inversion in GF(2^8) wrapped in an affine map.

Top module: `sm4_key_expander`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted only at a clock edge where `req_valid` and `req_ready` are both 1. From the following cycle, `req_ready` stays 0 until the schedule finishes, and it is 1 again in the same cycle that `done` rises.
- R3: `done` is 0 in the cycle after an accept. It becomes 1 exactly 32 clock edges after the accepting edge and holds until the next accept.
- R4: For the key 0123456789abcdeffedcba9876543210 (first 32-bit word = bits 127:96), the stored round keys are: index 0 = f12186f9, index 1 = 41662b61, index 2 = 5a6ab19a, index 3 = 7ba92077, index 31 = 9124a012. This covers the family-constant XOR in round 0 only, the round constants (byte j of constant r = 7*(4r+j) mod 256, byte 0 most significant), the byte substitution and the 13/23-bit rotation mix.
- R5: `rd_key` shows the round key at the `rd_idx` sampled at the previous clock edge (one cycle of read latency). Back-to-back index changes are served on consecutive cycles.
- R6: A request made while a schedule runs has no effect: it is not acknowledged, and the keys stored at the end are those of the key already accepted.
- R7: A new request after `done` restarts the schedule and overwrites every round key with the keys of the new cipher key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A cipher key is offered |
| req_ready | output | 1 | Unit is idle and takes a key at this edge |
| req_key | input | 128 | Cipher key, first word in bits 127:96 |
| done | output | 1 | All round keys of the last accepted key are stored |
| rd_idx | input | 5 | Round key index to read |
| rd_key | output | 32 | Round key at the index sampled one edge earlier |

## Verification
The bench counts every edge from the accepting one. It samples `done` on the falling edge after edges 31 and 32, expecting 0 and then 1. `req_ready` is expected low on the falling edge right after the accept. Each read sets `rd_idx` on a falling edge and compares `rd_key` on the next falling edge, after exactly one register. Known schedule outputs of the standard test key serve as the reference. A second key and a rerun show that each schedule overwrites the stored keys of the one before.

// File: rtl/sm4ks_pkg.sv
package sm4ks_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int NWORDS = 4;
  localparam int KEY_W  = WORD_W * NWORDS;

  // fixed constant folded into the key in the first round only
  localparam logic [KEY_W-1:0] FAMILY_CONST =
    {32'ha3b1bac6, 32'h56aa3350, 32'h677d9197, 32'hb27022dc};

  // low byte of the field polynomial x^8+x^7+x^6+x^5+x^4+x^2+1
  localparam logic [7:0] GF_POLY = 8'hF5;
  localparam logic [7:0] AFF_C   = 8'hD3;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] sh;
    p  = 8'h00;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ GF_POLY) : {sh[6:0], 1'b0};
    end
    return p;
  endfunction

  // a^254 is the multiplicative inverse, and 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] a);
    return a ^ {a[0], a[7:1]} ^ {a[1:0], a[7:2]} ^ {a[4:0], a[7:5]}
             ^ {a[6:0], a[7]} ^ AFF_C;
  endfunction

  function automatic logic [7:0] subst_byte(input logic [7:0] a);
    return affine(gf_inv(affine(a)));
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  // byte j of the round constant is 7*(4r+j) mod 256, byte 0 on top
  function automatic logic [WORD_W-1:0] round_const(input int r);
    logic [WORD_W-1:0] w;
    int v;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      v = (7 * (4 * r + j)) & 255;
      w[WORD_W-1-BYTE_W*j -: BYTE_W] = v[7:0];
    end
    return w;
  endfunction
endpackage

// File: rtl/sm4ks_mix.sv
module sm4ks_mix
  import sm4ks_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] subbed;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign subbed[g*BYTE_W +: BYTE_W] = subst_byte(din[g*BYTE_W +: BYTE_W]);
  end

  assign dout = subbed ^ rotl(subbed, 13) ^ rotl(subbed, 23);
endmodule

// File: rtl/sm4ks_round.sv
module sm4ks_round
  import sm4ks_pkg::*;
(
  input  logic [KEY_W-1:0]  state_in,
  input  logic              first,
  input  logic [WORD_W-1:0] rconst,
  output logic [KEY_W-1:0]  state_out,
  output logic [WORD_W-1:0] new_word
);
  logic [KEY_W-1:0]  eff;
  logic [WORD_W-1:0] w0, w1, w2, w3, mixed;

  assign eff = first ? (state_in ^ FAMILY_CONST) : state_in;
  assign {w0, w1, w2, w3} = eff;

  sm4ks_mix u_mix (
    .din  (w1 ^ w2 ^ w3 ^ rconst),
    .dout (mixed)
  );

  assign new_word  = mixed ^ w0;
  assign state_out = {w1, w2, w3, new_word};
endmodule

// File: rtl/sm4ks_keyram.sv
module sm4ks_keyram #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sm4_key_expander.sv
module sm4_key_expander
  import sm4ks_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int IDX_W = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KEY_W-1:0]  req_key,
  output logic              done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_key
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  logic              busy;
  logic [IDX_W-1:0]  rnd;
  logic [KEY_W-1:0]  state, state_nx;
  logic [WORD_W-1:0] rk_new, rconst;
  logic              accept;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign rconst    = round_const(int'(rnd));

  sm4ks_round u_round (
    .state_in  (state),
    .first     (rnd == '0),
    .rconst    (rconst),
    .state_out (state_nx),
    .new_word  (rk_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rnd   <= '0;
      state <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      rnd   <= '0;
      state <= req_key;
    end else if (busy) begin
      state <= state_nx;
      rnd   <= rnd + 1'b1;
      if (rnd == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  sm4ks_keyram #(.DEPTH(ROUNDS), .W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (busy),
    .waddr (rnd),
    .wdata (rk_new),
    .raddr (rd_idx),
    .rdata (rd_key)
  );
endmodule

// File: rtl/sm4ks_checker.sv
module sm4ks_checker #(
  parameter int ROUNDS = 32
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic done
);
  localparam int CW = $clog2(ROUNDS) + 2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (req_valid && req_ready) run_cnt <= '0;
    else if (!req_ready) run_cnt <= run_cnt + 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !done)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !done)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R2

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (run_cnt == CW'(ROUNDS))); // R3

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !req_valid) |=> done); // R3
endmodule

bind sm4_key_expander sm4ks_checker #(.ROUNDS(ROUNDS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done)
);

// File: tb/tb_sm4_key_expander.sv
`timescale 1ns/1ps
module tb_sm4_key_expander;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [127:0] req_key = '0;
  logic         done;
  logic [4:0]   rd_idx = '0;
  logic [31:0]  rd_key;

  int checks = 0;
  int errors = 0;

  localparam logic [127:0] STD_KEY = 128'h0123456789abcdeffedcba9876543210;
  localparam logic [127:0] ALT_KEY = 128'h00000000000000000000000000000000;

  always #5 clk = ~clk;

  sm4_key_expander dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_key(req_key), .done(done), .rd_idx(rd_idx), .rd_key(rd_key)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_key(input logic [4:0] idx, output logic [31:0] val);
    rd_idx = idx;
    @(negedge clk);
    val = rd_key;
  endtask

  // offers a key for one edge, then checks the run timing
  task automatic run_key(input logic [127:0] key, input bit noisy);
    req_key   = key;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 ready low after accept", 32'(req_ready), 32'd0);
    chk("R3 done low after accept", 32'(done), 32'd0);
    for (int i = 1; i < 31; i++) begin
      if (noisy && i >= 3 && i < 9) begin
        req_key   = ~key;
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      if (noisy) chk("R6 busy request not acknowledged", 32'(req_ready), 32'd0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R3 done low after 31 edges", 32'(done), 32'd0);
    @(negedge clk);
    chk("R3 done high after 32 edges", 32'(done), 32'd1);
    chk("R2 ready back with done", 32'(req_ready), 32'd1);
  endtask

  task automatic check_std(input string req);
    logic [31:0] v;
    read_key(5'd0, v);  chk({req, " R4 key 0"}, v, 32'hf12186f9);
    read_key(5'd1, v);  chk({req, " R4 key 1"}, v, 32'h41662b61);
    read_key(5'd2, v);  chk({req, " R4 key 2"}, v, 32'h5a6ab19a);
    read_key(5'd3, v);  chk({req, " R4 key 3"}, v, 32'h7ba92077);
    read_key(5'd31, v); chk({req, " R4 key 31"}, v, 32'h9124a012);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 done after reset", 32'(done), 32'd0);
  endtask

  task automatic test_standard();
    run_key(STD_KEY, 1'b0);
    check_std("R4");
  endtask

  task automatic test_read_latency();
    logic [31:0] v;
    rd_idx = 5'd31;
    @(negedge clk);
    rd_idx = 5'd0;
    chk("R5 previous index served", rd_key, 32'h9124a012);
    @(negedge clk);
    chk("R5 new index after one edge", rd_key, 32'hf12186f9);
    read_key(5'd2, v);
    chk("R5 back-to-back read", v, 32'h5a6ab19a);
  endtask

  task automatic test_busy_ignored();
    run_key(STD_KEY, 1'b1);
    check_std("R6");
  endtask

  task automatic test_rerun();
    logic [31:0] v0, v31;
    run_key(ALT_KEY, 1'b0);
    read_key(5'd0, v0);
    read_key(5'd31, v31);
    checks++;
    if (v0 == 32'hf12186f9 || v31 == 32'h9124a012) begin
      errors++;
      $display("FAIL R7 keys not replaced: actual %h %h expected not %h %h",
               v0, v31, 32'hf12186f9, 32'h9124a012);
    end
    run_key(STD_KEY, 1'b0);
    check_std("R7 rerun");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_standard();
    test_read_latency();
    test_busy_ignored();
    test_rerun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule